// File: doc/BRIEF.md
# Write-Status Polling Read Responder

This block is the read side of a byte-wide non-volatile memory whose writes are followed by a long, self-timed programming cycle. It watches the active-low chip-select and output-enable strobes. A read is in progress only while both strobes are low, and the block drives the data bus only during a read. At all other times its output enable is low, so the bus pad is high impedance.

While the write sequencer reports that programming is in progress, the block does not return array data. It returns a status word instead. The top bit is the inverse of the top bit of the last byte written, so a host polling that byte sees the wrong value until programming finishes. The next bit changes level once per read access, so a host that compares two back-to-back reads sees a difference while the part is busy. The remaining low bits carry the low bits of the last byte written. Once busy drops, reads return the array data again and the toggling bit holds its level.

The strobes pass through a synchroniser of `SYNC_STAGES` flops. A state machine then chooses the data source:

- `ST_IDLE`: not driving.
- `ST_ARRAY`: driving array data.
- `ST_STATUS`: driving the status overlay.

The transitions are:

- `ST_IDLE`→`ST_ARRAY` on access start while not busy.
- `ST_IDLE`→`ST_STATUS` on access start while busy.
- `ST_ARRAY`→`ST_STATUS` when busy rises mid-access.
- `ST_STATUS`→`ST_ARRAY` when busy falls mid-access.
- `ST_ARRAY`/`ST_STATUS`→`ST_IDLE` when either strobe rises.

Top module: `rdpoll_responder`

## Requirements
- R1: `bus_oe` is low whenever `ce_n` or `oe_n` has been high for `SYNC_STAGES`+1 consecutive clock cycles. It is high while both have been low for that long.
- R2: During a read with `busy` low, `bus_dout` equals `arr_rdata` and follows it within the same access.
- R3: During a read with `busy` high, bit DW-1 (bit 7 by default) of `bus_dout` is the inverse of bit DW-1 of `last_data`.
- R4: During a read with `busy` high, bit DW-2 (bit 6) of `bus_dout` takes a new level at the start of each read access. It stays constant for the whole of one access.
- R5: During a read with `busy` high, bits DW-3..0 of `bus_dout` equal the same bits of `last_data`.
- R6: During a read with `busy` high, `arr_rdata` has no effect on `bus_dout`. Every address therefore reads the same status word.
- R7: If `busy` falls during an access, `bus_dout` switches to `arr_rdata` within that access, without a new access.
- R8: Read accesses that start with `busy` low do not change the level of the toggling bit.
- R9: After reset the block is idle with `bus_oe` low and the toggle at 0, so the first busy read shows bit DW-2 as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip select strobe, active low |
| oe_n | input | 1 | Output enable strobe, active low |
| busy | input | 1 | Programming cycle in progress, from the write sequencer |
| last_data | input | DW | Last byte accepted by the write sequencer |
| arr_rdata | input | DW | Array read data for the current bus address |
| bus_dout | output | DW | Data to the bus pad |
| bus_oe | output | 1 | Pad drive enable; pad is high impedance when low |

## Verification
Two things can land on the same clock edge: the start of a read access, and `busy` falling. The access start decides whether the toggle advances, and the busy level decides the data source. The bench provokes this by lowering both strobes and then releasing `busy` exactly `SYNC_STAGES` edges later, so that the synchronised access start and the low busy level meet at the state register together. It judges the result in two ways: the access must show array data, and the next busy read must show a toggle level that proves the coincident access was not counted.

// File: rtl/rdpoll_pkg.sv
package rdpoll_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARRAY  = 2'd1,
        ST_STATUS = 2'd2
    } rd_state_e;

    function automatic logic state_drives(input rd_state_e s);
        return (s != ST_IDLE);
    endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_n,
    output logic q_n
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= d_n;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b1;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q_n = chain_q[STAGES-1];
endmodule

// File: rtl/access_tracker.sv
module access_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_s_n,
    input  logic oe_s_n,
    output logic active,
    output logic start
);
    logic active_q;

    assign active = ~ce_s_n & ~oe_s_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) active_q <= 1'b0;
        else        active_q <= active;
    end

    assign start = active & ~active_q;
endmodule

// File: rtl/toggle_reg.sv
module toggle_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    output logic level
);
    logic level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       level_q <= 1'b0;
        else if (advance) level_q <= ~level_q;
    end

    assign level = level_q;
endmodule

// File: rtl/status_overlay.sv
module status_overlay #(
    parameter int DW = 8
) (
    input  logic          use_status,
    input  logic [DW-1:0] last_data,
    input  logic          toggle_lvl,
    input  logic [DW-1:0] arr_rdata,
    output logic [DW-1:0] rd_word
);
    localparam int POLL_BIT = DW - 1;
    localparam int TOG_BIT  = DW - 2;

    logic [DW-1:0] status_word;

    always_comb begin
        status_word           = last_data;
        status_word[POLL_BIT] = ~last_data[POLL_BIT];
        status_word[TOG_BIT]  = toggle_lvl;
        rd_word = use_status ? status_word : arr_rdata;
    end
endmodule

// File: rtl/rdpoll_responder.sv
module rdpoll_responder
    import rdpoll_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          busy,
    input  logic [DW-1:0] last_data,
    input  logic [DW-1:0] arr_rdata,
    output logic [DW-1:0] bus_dout,
    output logic          bus_oe
);
    logic      ce_s_n, oe_s_n;
    logic      active, start;
    logic      tog_lvl;
    logic      use_status;
    rd_state_e state_q, state_d;

    strobe_sync #(.STAGES(SYNC_STAGES)) u_ce_sync (
        .clk(clk), .rst_n(rst_n), .d_n(ce_n), .q_n(ce_s_n)
    );

    strobe_sync #(.STAGES(SYNC_STAGES)) u_oe_sync (
        .clk(clk), .rst_n(rst_n), .d_n(oe_n), .q_n(oe_s_n)
    );

    access_tracker u_trk (
        .clk(clk), .rst_n(rst_n), .ce_s_n(ce_s_n), .oe_s_n(oe_s_n),
        .active(active), .start(start)
    );

    toggle_reg u_tog (
        .clk(clk), .rst_n(rst_n), .advance(start & busy), .level(tog_lvl)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (active) state_d = busy ? ST_STATUS : ST_ARRAY;
            ST_ARRAY:  if (!active) state_d = ST_IDLE;
                       else if (busy) state_d = ST_STATUS;
            ST_STATUS: if (!active) state_d = ST_IDLE;
                       else if (!busy) state_d = ST_ARRAY;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        bus_oe     = state_drives(state_q);
        use_status = (state_q == ST_STATUS);
    end

    status_overlay #(.DW(DW)) u_ovl (
        .use_status(use_status), .last_data(last_data), .toggle_lvl(tog_lvl),
        .arr_rdata(arr_rdata), .rd_word(bus_dout)
    );
endmodule

// File: rtl/rdpoll_responder_chk.sv
module rdpoll_responder_chk #(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_n,
    input logic          oe_n,
    input logic          busy,
    input logic [DW-1:0] last_data,
    input logic [DW-1:0] arr_rdata,
    input logic [DW-1:0] bus_dout,
    input logic          bus_oe
);
    localparam int LIM = SYNC_STAGES + 1;
    localparam int CW  = $clog2(LIM + 1);

    logic [CW-1:0] off_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              off_cnt <= '0;
        else if (!(ce_n | oe_n)) off_cnt <= '0;
        else if (off_cnt < CW'(LIM)) off_cnt <= off_cnt + 1'b1;
    end

    AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (off_cnt >= CW'(LIM)) |-> !bus_oe); // R1
    AST_ARRAY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && !$past(busy)) |-> (bus_dout == arr_rdata)); // R2
    AST_POLL_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && $past(busy)) |-> (bus_dout[DW-1] == ~last_data[DW-1])); // R3
    AST_TOG_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && $past(bus_oe) && $past(busy) && $past(busy, 2)) |-> $stable(bus_dout[DW-2])); // R4
    AST_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && $past(busy)) |-> (bus_dout[DW-3:0] == last_data[DW-3:0])); // R5
endmodule

bind rdpoll_responder rdpoll_responder_chk #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) chk_i (.*);

// File: tb/rdpoll_responder_tb_top.sv
module rdpoll_responder_tb_top;
    localparam int DW     = 8;
    localparam int SYNC   = 2;
    localparam int SETTLE = SYNC + 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, busy = 1'b0;
    logic [DW-1:0] last_data = '0, arr_rdata = '0;
    logic [DW-1:0] bus_dout;
    logic          bus_oe;

    int  n_checks = 0, n_fail = 0;
    bit  done = 1'b0;
    bit  tog = 1'b0;

    typedef struct {
        logic          oe;
        logic [DW-1:0] data;
        bit            chk_data;
        string         tag;
    } exp_t;

    exp_t exp_q[$];
    event chk_ev;

    always #10 clk = ~clk;

    rdpoll_responder #(.DW(DW), .SYNC_STAGES(SYNC)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .busy(busy),
        .last_data(last_data), .arr_rdata(arr_rdata),
        .bus_dout(bus_dout), .bus_oe(bus_oe)
    );

    function automatic logic [DW-1:0] status_of(input logic [DW-1:0] ld, input bit t);
        logic [DW-1:0] w;
        w = ld;
        w[DW-1] = ~ld[DW-1];
        w[DW-2] = t;
        return w;
    endfunction

    // Monitor
    initial begin
        forever begin
            exp_t e;
            @(chk_ev);
            while (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                n_checks++;
                if (bus_oe !== e.oe || (e.chk_data && bus_dout !== e.data)) begin
                    n_fail++;
                    $display("FAIL %s: oe=%b data=%h expected oe=%b data=%h",
                             e.tag, bus_oe, bus_dout, e.oe, e.data);
                end
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_now(input logic oe, input logic [DW-1:0] d, input bit cd, input string tag);
        exp_t e;
        e.oe = oe; e.data = d; e.chk_data = cd; e.tag = tag;
        exp_q.push_back(e);
        -> chk_ev;
        #1;
    endtask

    task automatic open_read();
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0;
    endtask

    task automatic close_read();
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        wait_cyc(SETTLE);
    endtask

    task automatic busy_read(input string tag);
        open_read();
        wait_cyc(SETTLE);
        tog = ~tog;
        expect_now(1'b1, status_of(last_data, tog), 1'b1, tag);
    endtask

    initial begin
        wait_cyc(3);
        expect_now(1'b0, '0, 1'b0, "R9 reset idle / R1");
        rst_n = 1'b1;
        wait_cyc(2);

        // Non-busy reads
        arr_rdata = 8'hA5;
        open_read(); wait_cyc(SETTLE);
        expect_now(1'b1, 8'hA5, 1'b1, "R2 array read");
        arr_rdata = 8'h3C; wait_cyc(1);
        expect_now(1'b1, 8'h3C, 1'b1, "R2 array follows");
        close_read();
        expect_now(1'b0, '0, 1'b0, "R1 idle after read");

        // Only one strobe low
        @(negedge clk); ce_n = 1'b0; wait_cyc(SETTLE);
        expect_now(1'b0, '0, 1'b0, "R1 oe_n high");
        ce_n = 1'b1; oe_n = 1'b0; wait_cyc(SETTLE);
        expect_now(1'b0, '0, 1'b0, "R1 ce_n high");
        oe_n = 1'b1; wait_cyc(SETTLE);

        // Busy reads
        busy = 1'b1; last_data = 8'h4B;
        busy_read("R3 R5 R9 first busy read");
        arr_rdata = 8'h00; wait_cyc(3);
        expect_now(1'b1, 8'hCB, 1'b1, "R6 R4 arr change held");
        close_read();
        busy_read("R4 second busy read");
        close_read();
        last_data = 8'hFF;
        busy_read("R3 R5 top bit one");
        arr_rdata = 8'h77; wait_cyc(2);
        expect_now(1'b1, status_of(8'hFF, tog), 1'b1, "R6 other address");
        close_read();

        // Busy falls mid access
        busy_read("R4 pre-release read");
        arr_rdata = 8'h5A;
        @(negedge clk); busy = 1'b0; wait_cyc(2);
        expect_now(1'b1, 8'h5A, 1'b1, "R7 busy falls mid access");
        close_read();

        // Non-busy reads do not flip toggle
        open_read(); wait_cyc(SETTLE); close_read();
        open_read(); wait_cyc(SETTLE); close_read();
        busy = 1'b1; last_data = 8'h12;
        busy_read("R8 toggle held across idle reads");
        close_read();

        // Access start coincides with busy falling
        arr_rdata = 8'hE1;
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk); busy = 1'b0;
        wait_cyc(SETTLE);
        expect_now(1'b1, 8'hE1, 1'b1, "R2 R8 coincident start and busy low");
        close_read();
        busy = 1'b1; last_data = 8'h6E;
        busy_read("R8 coincident access not counted");
        close_read();
        busy = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule